// File: doc/BRIEF.md
# Canonical-Signed-Digit Coefficient Multiplier

This block multiplies a signed fixed-point sample by a filter coefficient. The coefficient is not a plain binary number. It is a short list of signed power-of-two digits, each packed into a 4-bit nibble. Each nibble gives a sign and a shift count for one nonzero binary digit of the coefficient.

A digit's shift is measured from the digit before it, not from the binary point. The weights therefore build up along the list and must be evaluated in list order. The block handles one digit per clock. It keeps a running shift total and a wide accumulator that holds every fractional bit. At the end it drops the fraction and returns the integer product.

A static digit-count input selects whether 2, 3 or 4 digits take part. A caller raises `start_i` for one cycle while the block is idle. A one-cycle `valid_o` pulse then marks the new product on `product_o`.

Top module: `csd_mult`

## Requirements
- R1: Each digit nibble holds the sign in bit 3 (0 adds the term, 1 subtracts it). Bits 2:0 hold an unsigned binary shift count from 0 to 7.
- R2: The first digit (the most significant nonzero binary 1) sits in `coef_i[15:12]`. Each following digit sits in the next lower nibble, down to `coef_i[3:0]`.
- R3: Digit x has weight 2^-(m1+...+mx), where m1 to mx are the shift counts of digits 1 to x. Shifts accumulate along the list.
- R4: `product_o` is the 18-bit two's-complement value floor(sample × h). Here h is the signed sum of the active digit weights, so the dropped fraction always rounds toward minus infinity.
- R5: `ndig_i` gives the number of active digits as 2, 3 or 4. A value below 2 acts as 2, and a value above 4 acts as 4.
- R6: Nibbles beyond the active digit count have no effect on the product.
- R7: `valid_o` is high for exactly one cycle. It rises on the Nth rising clock edge after the edge that accepted the start, where N is the effective digit count.
- R8: The block captures `sample_i`, `coef_i` and `ndig_i` when it accepts a start. It ignores `start_i` while `busy_o` is high, and later changes on the inputs do not affect the result in progress.
- R9: After reset, `valid_o`, `busy_o` and `product_o` are all 0. `product_o` holds its last value until the next result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiply; honoured only while idle |
| sample_i | input | 16 | Signed sample |
| coef_i | input | 16 | Four packed digit nibbles, first digit in the top nibble |
| ndig_i | input | 3 | Active digit count (2 to 4, clamped) |
| busy_o | output | 1 | A multiply is in progress |
| valid_o | output | 1 | One-cycle pulse: `product_o` has just been updated |
| product_o | output | 18 | Signed product, fraction truncated toward minus infinity |

## Verification
Two situations are the hardest to reach from the ports.

The first is a deep cumulative shift, where every digit uses code 7 and the last term lands 28 bits below the binary point. The bench drives a full-scale sample with that coefficient. It also drives a negative sample with a small residual term, so that floor truncation differs from truncation toward zero.

The second is a start pulse and changed inputs arriving in the middle of a run. The bench raises a second start, with other operands, one cycle after a four-digit run begins. The scoreboard then flags any extra `valid_o` pulse or any corrupted product.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int unsigned CSD_SHIFT_W = 3;
  localparam int unsigned CSD_NIB_W   = CSD_SHIFT_W + 1;

  typedef struct packed {
    logic                   neg;
    logic [CSD_SHIFT_W-1:0] shamt;
  } csd_digit_t;
endpackage

// File: rtl/csd_digit_sel.sv
module csd_digit_sel
  import csd_pkg::*;
#(
  parameter int unsigned MAX_DIGITS = 4,
  localparam int unsigned IDX_W     = $clog2(MAX_DIGITS)
) (
  input  logic [MAX_DIGITS*CSD_NIB_W-1:0] coef_i,
  input  logic [IDX_W-1:0]                idx_i,
  output csd_digit_t                      dig_o
);
  csd_digit_t digs [MAX_DIGITS];

  // first digit lives in the top nibble
  for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_unpack
    assign digs[g] = csd_digit_t'(coef_i[(MAX_DIGITS-g)*CSD_NIB_W-1 -: CSD_NIB_W]);
  end

  assign dig_o = digs[idx_i];
endmodule

// File: rtl/csd_seq_ctrl.sv
module csd_seq_ctrl #(
  parameter int unsigned MAX_DIGITS = 4,
  parameter int unsigned MIN_DIGITS = 2,
  localparam int unsigned IDX_W     = $clog2(MAX_DIGITS),
  localparam int unsigned N_W       = $clog2(MAX_DIGITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_W-1:0]   ndig_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             final_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q, last_q, last_d;
  logic [N_W-1:0]   n_eff, n_m1;

  always_comb begin
    if (ndig_i < N_W'(MIN_DIGITS))      n_eff = N_W'(MIN_DIGITS);
    else if (ndig_i > N_W'(MAX_DIGITS)) n_eff = N_W'(MAX_DIGITS);
    else                                n_eff = ndig_i;
    n_m1   = n_eff - N_W'(1);
    last_d = n_m1[IDX_W-1:0];
  end

  assign accept_o = start_i & ~busy_q;
  assign final_o  = busy_q & (idx_q == last_q);
  assign busy_o   = busy_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      last_q <= last_d;
    end else if (busy_q) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + IDX_W'(1);
    end
  end

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q && idx_q == '0);
  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(last_q));
  p_run_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && idx_q != last_q |=> busy_q && idx_q == $past(idx_q) + IDX_W'(1));
endmodule

// File: rtl/csd_accum.sv
module csd_accum
  import csd_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned MAX_DIGITS = 4,
  localparam int unsigned FRAC_W    = MAX_DIGITS * ((1 << CSD_SHIFT_W) - 1),
  localparam int unsigned CUM_W     = $clog2(FRAC_W + 1),
  localparam int unsigned PROD_W    = DATA_W + $clog2(MAX_DIGITS),
  localparam int unsigned ACC_W     = DATA_W + FRAC_W + $clog2(MAX_DIGITS) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     accept_i,
  input  logic                     step_i,
  input  logic                     final_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  csd_digit_t               dig_i,
  output logic signed [PROD_W-1:0] product_o,
  output logic                     valid_o
);
  logic signed [DATA_W-1:0] sample_q;
  logic signed [ACC_W-1:0]  acc_q, acc_next, base, term;
  logic [CUM_W-1:0]         cum_q, cum_next;
  logic signed [PROD_W-1:0] prod_q;
  logic                     valid_q;

  always_comb begin
    cum_next = cum_q + CUM_W'(dig_i.shamt);
    base     = {{(ACC_W-DATA_W){sample_q[DATA_W-1]}}, sample_q} <<< FRAC_W;
    term     = base >>> cum_next;
    acc_next = dig_i.neg ? acc_q - term : acc_q + term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      acc_q    <= '0;
      cum_q    <= '0;
      prod_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (accept_i) begin
        sample_q <= sample_i;
        acc_q    <= '0;
        cum_q    <= '0;
      end else if (step_i) begin
        acc_q <= acc_next;
        cum_q <= cum_next;
        if (final_i) begin
          // keep integer part only: floor of the scaled sum
          prod_q  <= acc_next[FRAC_W +: PROD_W];
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign product_o = prod_q;
  assign valid_o   = valid_q;

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(prod_q));
  p_cum_grows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !final_i |=> cum_q >= $past(cum_q));
endmodule

// File: rtl/csd_mult.sv
module csd_mult
  import csd_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned MAX_DIGITS = 4,
  parameter int unsigned MIN_DIGITS = 2,
  localparam int unsigned COEF_W    = MAX_DIGITS * CSD_NIB_W,
  localparam int unsigned N_W       = $clog2(MAX_DIGITS + 1),
  localparam int unsigned IDX_W     = $clog2(MAX_DIGITS),
  localparam int unsigned PROD_W    = DATA_W + $clog2(MAX_DIGITS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [COEF_W-1:0]        coef_i,
  input  logic [N_W-1:0]           ndig_i,
  output logic                     busy_o,
  output logic                     valid_o,
  output logic signed [PROD_W-1:0] product_o
);
  logic             accept, busy, final_d;
  logic [IDX_W-1:0] idx;
  logic [COEF_W-1:0] coef_q;
  csd_digit_t       dig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     coef_q <= '0;
    else if (accept) coef_q <= coef_i;
  end

  csd_seq_ctrl #(.MAX_DIGITS(MAX_DIGITS), .MIN_DIGITS(MIN_DIGITS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ndig_i   (ndig_i),
    .accept_o (accept),
    .busy_o   (busy),
    .final_o  (final_d),
    .idx_o    (idx)
  );

  csd_digit_sel #(.MAX_DIGITS(MAX_DIGITS)) u_sel (
    .coef_i (coef_q),
    .idx_i  (idx),
    .dig_o  (dig)
  );

  csd_accum #(.DATA_W(DATA_W), .MAX_DIGITS(MAX_DIGITS)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .step_i    (busy),
    .final_i   (final_d),
    .sample_i  (sample_i),
    .dig_i     (dig),
    .product_o (product_o),
    .valid_o   (valid_o)
  );

  assign busy_o = busy;

  p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
  p_coef_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(coef_q));
endmodule

// File: tb/csd_mult_tb.sv
module csd_mult_tb;
  localparam int DW = 16;
  localparam int PW = 18;
  localparam int FW = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic signed [DW-1:0] sample_i = '0;
  logic [15:0] coef_i = '0;
  logic [2:0]  ndig_i = 3'd2;
  logic busy_o, valid_o;
  logic signed [PW-1:0] product_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  longint exp_q[$];
  int     cyc_q[$];
  int     n_q[$];
  string  tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  csd_mult u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .sample_i(sample_i),
    .coef_i(coef_i), .ndig_i(ndig_i), .busy_o(busy_o), .valid_o(valid_o),
    .product_o(product_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clamp_n(input logic [2:0] n);
    if (n < 3'd2) return 2;
    if (n > 3'd4) return 4;
    return int'(n);
  endfunction

  // R1 R2 R3 R4 model: exact signed sum of digit weights, then floor
  function automatic longint ref_prod(input longint s, input logic [15:0] c, input logic [2:0] n);
    longint num;
    longint p;
    int cum;
    logic [3:0] nib;
    num = 0;
    cum = 0;
    for (int x = 0; x < clamp_n(n); x++) begin
      nib = c[15-4*x -: 4];
      cum += int'(nib[2:0]);
      if (nib[3]) num -= (64'sd1 <<< (FW - cum));
      else        num += (64'sd1 <<< (FW - cum));
    end
    p = (s * num) >>> FW;
    return p;
  endfunction

  task automatic run(input logic signed [DW-1:0] s, input logic [15:0] c,
                     input logic [2:0] n, input string tag);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    sample_i = s; coef_i = c; ndig_i = n; start_i = 1'b1;
    exp_q.push_back(ref_prod(longint'(s), c, n));
    cyc_q.push_back(cyc + 1);
    n_q.push_back(clamp_n(n));
    tag_q.push_back(tag);
    @(negedge clk);
    start_i = 1'b0;
    // R8: disturb inputs while busy
    sample_i = ~s; coef_i = ~c; ndig_i = ~n;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected valid", longint'(product_o), 0);
      end else begin
        longint e;
        int sc, nn;
        string tg;
        e = exp_q.pop_front(); sc = cyc_q.pop_front();
        nn = n_q.pop_front(); tg = tag_q.pop_front();
        check(longint'(product_o) == e, tg, longint'(product_o), e);
        check(cyc - sc == nn, "R7 latency", longint'(cyc - sc), longint'(nn));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic signed [PW-1:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(valid_o == 1'b0, "R9 reset valid", longint'(valid_o), 0);
    check(busy_o == 1'b0, "R9 reset busy", longint'(busy_o), 0);
    check(product_o == '0, "R9 reset product", longint'(product_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(16'sd1000, 16'h1100, 3'd2, "R3 0.5+0.25");
    run(16'sd1000, 16'h8200, 3'd2, "R1 negative first digit");
    run(16'sd1000, 16'h1300, 3'd2, "R2 order a");
    run(16'sd1000, 16'h3100, 3'd2, "R2 order b");
    run(-16'sd1, 16'h1700, 3'd2, "R4 floor negative");
    run(16'sd3, 16'h1700, 3'd2, "R4 floor positive");
    run(-16'sd32768, 16'h0000, 3'd4, "R4 min sample h=4");
    run(16'sd32767, 16'h0000, 3'd4, "R4 max sample h=4");
    run(16'sd32767, 16'h7777, 3'd4, "R3 deep shift");
    run(-16'sd12345, 16'h123F, 3'd3, "R6 fourth nibble ignored");
    run(-16'sd12345, 16'h1230, 3'd3, "R6 reference");
    run(-16'sd12345, 16'h123F, 3'd4, "R5 four digits");
    run(16'sd777, 16'h19AB, 3'd0, "R5 clamp low");
    run(16'sd777, 16'h19AB, 3'd7, "R5 clamp high");
    run(16'sd4321, 16'h2A3C, 3'd3, "R5 three digits");

    // R8: start while busy is ignored
    run(16'sd2000, 16'h2121, 3'd4, "R8 first run kept");
    start_i = 1'b1; sample_i = 16'sd9; coef_i = 16'h0000; ndig_i = 3'd2;
    @(negedge clk);
    start_i = 1'b0;

    for (int i = 0; i < 20; i++) begin
      run($signed(16'($urandom)), 16'($urandom), 3'($urandom_range(2, 4)), "R4 random");
    end

    while (exp_q.size() != 0) @(negedge clk);
    // R9 hold after result
    held = product_o;
    repeat (6) @(negedge clk);
    check(product_o == held, "R9 hold product", longint'(product_o), longint'(held));
    check(valid_o == 1'b0, "R9 no extra valid", longint'(valid_o), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule